// File: doc/BRIEF.md
# Tag-Wakeup Issue Queue

This block sits between the dispatch stage of an out-of-order core and one functional unit. Each dispatched operation enters with an opcode, a destination tag and two source operands. Every source operand is either already present, with its value attached, or still being produced, in which case it carries the tag of its producer. The queue watches a shared result broadcast. When a broadcast tag matches a waiting operand, that operand latches the broadcast value and becomes ready.

Each cycle the queue offers at most one fully ready operation to its functional unit. It offers nothing while the unit reports itself busy. Among several ready operations the one inserted earliest goes first. A broadcast that arrives in the same cycle as the operation that needs it still wakes that operation. When every slot is taken, the dispatch side sees the queue as not ready and anything it presents is dropped.

Top module: `tag_wakeup_iq`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1 and `iss_valid` is 0.
- R2: A source operand whose ready bit is 1, or whose tag is 0, is ready on entry and keeps its dispatched value. An entry with both sources ready in this way raises `iss_valid` in the cycle after its dispatch edge, provided `fu_busy` is 0.
- R3: A source operand that is not ready on entry waits for its tag. A broadcast with `bc_valid`=1 and that tag makes it ready and stores `bc_value`. The entry can issue in the cycle after the broadcast edge, and not before all of its sources are ready.
- R4: A broadcast with a different tag, or with `bc_valid`=0, wakes nothing.
- R5: A broadcast in the same cycle as dispatch wakes a matching source of the entry being inserted and stores `bc_value`.
- R6: While `fu_busy` is 1, `iss_valid` is 0. Ready entries stay queued and issue once `fu_busy` falls.
- R7: With all DEPTH slots occupied, `disp_ready` is 0 and a dispatch offered then never enters the queue.
- R8: When several entries are ready, the one dispatched earliest is issued first, whatever slot it occupies.
- R9: An entry leaves the queue at the edge that ends its issue cycle. A full queue therefore shows `disp_ready`=1 from the next cycle, not during the issue cycle.
- R10: The issue port presents the opcode, destination tag and both operand values of the selected entry. Operand A is source index 0 and operand B is source index 1.
- R11: One broadcast wakes every waiting operand with that tag, across both sources and across several entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | A slot is free; the offer is taken when both are 1 |
| disp_op | input | OP_W | Opcode |
| disp_tag_a | input | TAG_W | Producer tag of operand A (0 = present) |
| disp_rdy_a | input | 1 | Operand A value is present |
| disp_val_a | input | DATA_W | Operand A value when present |
| disp_tag_b | input | TAG_W | Producer tag of operand B (0 = present) |
| disp_rdy_b | input | 1 | Operand B value is present |
| disp_val_b | input | DATA_W | Operand B value when present |
| disp_dst | input | TAG_W | Destination tag |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Broadcast tag |
| bc_value | input | DATA_W | Broadcast result value |
| fu_busy | input | 1 | Functional unit cannot accept this cycle |
| iss_valid | output | 1 | An operation is issued this cycle |
| iss_op | output | OP_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_val_a | output | DATA_W | Issued operand A |
| iss_val_b | output | DATA_W | Issued operand B |

## Verification
Nine operand shapes are swept. Each operand is made present either by its ready bit or by a zero tag, or is left waiting, and every pairing of these shapes is dispatched once. This separates the two ways of being present from a real wait, and a single wake from the need for both wakes. Waiting entries first see a broadcast with the wrong tag and then a matching tag with the valid bit low, so that false wakes show up as early issues. Further runs cover a broadcast that coincides with insertion, a busy unit holding a ready entry, filling the queue and offering one more, draining in order, one tag shared by several operands, and an order in which the oldest entry sits in a higher slot than a younger one. That last case separates age order from slot order.

// File: rtl/tag_wakeup_iq_pkg.sv
package tag_wakeup_iq_pkg;

    localparam int unsigned NUM_SRC      = 2;
    localparam int unsigned DEF_DEPTH    = 4;
    localparam int unsigned DEF_TAG_W    = 6;
    localparam int unsigned DEF_DATA_W   = 32;
    localparam int unsigned DEF_OP_W     = 4;

    // An operand counts as present if flagged so, or if it names tag zero.
    function automatic logic src_present(input logic rdy_bit, input logic tag_is_zero);
        return rdy_bit | tag_is_zero;
    endfunction

    // A broadcast hits an operand only when valid and the tags agree.
    function automatic logic bc_hit(input logic bc_vld, input logic tags_equal);
        return bc_vld & tags_equal;
    endfunction

endpackage

// File: rtl/wiq_lowest.sv
module wiq_lowest #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] oh_o,
    output logic         any_o
);
    logic found;

    always_comb begin
        oh_o  = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i] && !found) begin
                oh_o[i] = 1'b1;
                found   = 1'b1;
            end
        end
        any_o = found;
    end
endmodule

// File: rtl/wiq_entry.sv
module wiq_entry
    import tag_wakeup_iq_pkg::*;
#(
    parameter int unsigned OP_W   = DEF_OP_W,
    parameter int unsigned TAG_W  = DEF_TAG_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ins_i,
    input  logic                             clr_i,
    input  logic [OP_W-1:0]                  ins_op_i,
    input  logic [TAG_W-1:0]                 ins_dst_i,
    input  logic [NUM_SRC-1:0][TAG_W-1:0]    ins_tag_i,
    input  logic [NUM_SRC-1:0]               ins_rdy_i,
    input  logic [NUM_SRC-1:0][DATA_W-1:0]   ins_val_i,
    input  logic                             bc_valid_i,
    input  logic [TAG_W-1:0]                 bc_tag_i,
    input  logic [DATA_W-1:0]                bc_value_i,
    output logic                             valid_o,
    output logic                             ready_o,
    output logic [OP_W-1:0]                  op_o,
    output logic [TAG_W-1:0]                 dst_o,
    output logic [NUM_SRC-1:0][DATA_W-1:0]   val_o
);
    typedef struct packed {
        logic                           valid;
        logic [OP_W-1:0]                op;
        logic [TAG_W-1:0]               dst;
        logic [NUM_SRC-1:0]             rdy;
        logic [NUM_SRC-1:0][TAG_W-1:0]  tag;
        logic [NUM_SRC-1:0][DATA_W-1:0] val;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.valid = 1'b0;
        end
        if (ins_i) begin
            st_d.valid = 1'b1;
            st_d.op    = ins_op_i;
            st_d.dst   = ins_dst_i;
            st_d.tag   = ins_tag_i;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (src_present(ins_rdy_i[s], ins_tag_i[s] == '0)) begin
                    st_d.rdy[s] = 1'b1;
                    st_d.val[s] = ins_val_i[s];
                end else if (bc_hit(bc_valid_i, bc_tag_i == ins_tag_i[s])) begin
                    st_d.rdy[s] = 1'b1;
                    st_d.val[s] = bc_value_i;
                end else begin
                    st_d.rdy[s] = 1'b0;
                    st_d.val[s] = '0;
                end
            end
        end else if (st_q.valid) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (!st_q.rdy[s] && bc_hit(bc_valid_i, bc_tag_i == st_q.tag[s])) begin
                    st_d.rdy[s] = 1'b1;
                    st_d.val[s] = bc_value_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign ready_o = st_q.valid && (&st_q.rdy);
    assign op_o    = st_q.op;
    assign dst_o   = st_q.dst;
    assign val_o   = st_q.val;
endmodule

// File: rtl/wiq_age_pick.sv
module wiq_age_pick #(
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] ins_oh_i,
    input  logic [DEPTH-1:0] valid_i,
    input  logic [DEPTH-1:0] req_i,
    output logic [DEPTH-1:0] gnt_o,
    output logic             any_o
);
    // older_q[i][j] set: slot i was filled before slot j
    typedef struct packed {
        logic [DEPTH-1:0][DEPTH-1:0] older;
    } age_t;

    age_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < DEPTH; k++) begin
            if (ins_oh_i[k]) begin
                st_d.older[k] = '0;
                for (int j = 0; j < DEPTH; j++) begin
                    st_d.older[j][k] = valid_i[j] && (j != k);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [DEPTH-1:0] blocked;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                blocked[i] = blocked[i] | (req_i[j] & st_q.older[j][i]);
            end
            gnt_o[i] = req_i[i] & ~blocked[i];
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/tag_wakeup_iq.sv
module tag_wakeup_iq
    import tag_wakeup_iq_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned OP_W   = DEF_OP_W,
    parameter int unsigned TAG_W  = DEF_TAG_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_tag_a,
    input  logic              disp_rdy_a,
    input  logic [DATA_W-1:0] disp_val_a,
    input  logic [TAG_W-1:0]  disp_tag_b,
    input  logic              disp_rdy_b,
    input  logic [DATA_W-1:0] disp_val_b,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              fu_busy,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [DATA_W-1:0] iss_val_a,
    output logic [DATA_W-1:0] iss_val_b
);
    localparam int unsigned SRC_A = 0;
    localparam int unsigned SRC_B = 1;

    logic [DEPTH-1:0]                           ent_valid;
    logic [DEPTH-1:0]                           ent_ready;
    logic [DEPTH-1:0][OP_W-1:0]                 ent_op;
    logic [DEPTH-1:0][TAG_W-1:0]                ent_dst;
    logic [DEPTH-1:0][NUM_SRC-1:0][DATA_W-1:0]  ent_val;

    logic [DEPTH-1:0] free_oh;
    logic             free_any;
    logic [DEPTH-1:0] ins_oh;
    logic [DEPTH-1:0] gnt;
    logic [DEPTH-1:0] req;
    logic             req_any;
    logic             disp_fire;

    logic [NUM_SRC-1:0][TAG_W-1:0]  src_tag;
    logic [NUM_SRC-1:0]             src_rdy;
    logic [NUM_SRC-1:0][DATA_W-1:0] src_val;

    always_comb begin
        src_tag[SRC_A] = disp_tag_a;
        src_tag[SRC_B] = disp_tag_b;
        src_rdy[SRC_A] = disp_rdy_a;
        src_rdy[SRC_B] = disp_rdy_b;
        src_val[SRC_A] = disp_val_a;
        src_val[SRC_B] = disp_val_b;
    end

    wiq_lowest #(.W(DEPTH)) u_free (
        .vec_i (~ent_valid),
        .oh_o  (free_oh),
        .any_o (free_any)
    );

    assign disp_ready = free_any;
    assign disp_fire  = disp_valid && free_any;
    assign ins_oh     = free_oh & {DEPTH{disp_fire}};
    assign req        = ent_ready & {DEPTH{~fu_busy}};

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        wiq_entry #(
            .OP_W   (OP_W),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .ins_i      (ins_oh[g]),
            .clr_i      (gnt[g]),
            .ins_op_i   (disp_op),
            .ins_dst_i  (disp_dst),
            .ins_tag_i  (src_tag),
            .ins_rdy_i  (src_rdy),
            .ins_val_i  (src_val),
            .bc_valid_i (bc_valid),
            .bc_tag_i   (bc_tag),
            .bc_value_i (bc_value),
            .valid_o    (ent_valid[g]),
            .ready_o    (ent_ready[g]),
            .op_o       (ent_op[g]),
            .dst_o      (ent_dst[g]),
            .val_o      (ent_val[g])
        );
    end

    wiq_age_pick #(.DEPTH(DEPTH)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_oh_i (ins_oh),
        .valid_i  (ent_valid),
        .req_i    (req),
        .gnt_o    (gnt),
        .any_o    (req_any)
    );

    // AND-OR selection of the granted slot's payload
    always_comb begin
        iss_valid = req_any;
        iss_op    = '0;
        iss_dst   = '0;
        iss_val_a = '0;
        iss_val_b = '0;
        for (int i = 0; i < DEPTH; i++) begin
            iss_op    = iss_op    | (ent_op[i]         & {OP_W{gnt[i]}});
            iss_dst   = iss_dst   | (ent_dst[i]        & {TAG_W{gnt[i]}});
            iss_val_a = iss_val_a | (ent_val[i][SRC_A] & {DATA_W{gnt[i]}});
            iss_val_b = iss_val_b | (ent_val[i][SRC_B] & {DATA_W{gnt[i]}});
        end
    end
endmodule

// File: rtl/tag_wakeup_iq_chk.sv
module tag_wakeup_iq_chk #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TAG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [TAG_W-1:0] disp_tag_a,
    input logic             disp_rdy_a,
    input logic [TAG_W-1:0] disp_tag_b,
    input logic             disp_rdy_b,
    input logic             fu_busy,
    input logic             iss_valid
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] occ_q;
    logic          took;
    logic          both_present;

    assign took         = disp_valid && disp_ready;
    assign both_present = (disp_rdy_a || disp_tag_a == '0) && (disp_rdy_b || disp_tag_b == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + CW'(took) - CW'(iss_valid);
        end
    end

    // R6
    busy_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fu_busy |-> !iss_valid);

    // R7
    full_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == CW'(DEPTH)) |-> !disp_ready);

    // R9
    space_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q < CW'(DEPTH)) |-> disp_ready);

    // R10
    no_issue_from_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (occ_q != '0));

    // R2
    present_issues_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0 && took && both_present) |=> (fu_busy || iss_valid));

    // R1
    known_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({iss_valid, disp_ready}));
endmodule

bind tag_wakeup_iq tag_wakeup_iq_chk #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_tag_a (disp_tag_a),
    .disp_rdy_a (disp_rdy_a),
    .disp_tag_b (disp_tag_b),
    .disp_rdy_b (disp_rdy_b),
    .fu_busy    (fu_busy),
    .iss_valid  (iss_valid)
);

// File: tb/tag_wakeup_iq_bench.sv
module tag_wakeup_iq_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        disp_valid, disp_ready;
    logic [3:0]  disp_op;
    logic [5:0]  disp_tag_a, disp_tag_b, disp_dst;
    logic        disp_rdy_a, disp_rdy_b;
    logic [31:0] disp_val_a, disp_val_b;
    logic        bc_valid;
    logic [5:0]  bc_tag;
    logic [31:0] bc_value;
    logic        fu_busy;
    logic        iss_valid;
    logic [3:0]  iss_op;
    logic [5:0]  iss_dst;
    logic [31:0] iss_val_a, iss_val_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tag_wakeup_iq u_tag_wakeup_iq (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
        .disp_tag_a(disp_tag_a), .disp_rdy_a(disp_rdy_a), .disp_val_a(disp_val_a),
        .disp_tag_b(disp_tag_b), .disp_rdy_b(disp_rdy_b), .disp_val_b(disp_val_b),
        .disp_dst(disp_dst), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .fu_busy(fu_busy), .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_val_a(iss_val_a), .iss_val_b(iss_val_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        disp_valid = 0; disp_op = '0; disp_dst = '0;
        disp_tag_a = '0; disp_rdy_a = 0; disp_val_a = '0;
        disp_tag_b = '0; disp_rdy_b = 0; disp_val_b = '0;
        bc_valid = 0; bc_tag = '0; bc_value = '0; fu_busy = 0;
    endtask

    task automatic put(input logic [3:0] op, input logic [5:0] dst,
                       input logic [5:0] ta, input logic ra, input logic [31:0] va,
                       input logic [5:0] tb, input logic rb, input logic [31:0] vb);
        disp_valid = 1; disp_op = op; disp_dst = dst;
        disp_tag_a = ta; disp_rdy_a = ra; disp_val_a = va;
        disp_tag_b = tb; disp_rdy_b = rb; disp_val_b = vb;
    endtask

    task automatic see_issue(input string req, input logic [3:0] op, input logic [5:0] dst,
                             input logic [31:0] va, input logic [31:0] vb);
        chk({req, " valid"}, {31'b0, iss_valid}, 1);
        chk({req, " R10 op"}, {28'b0, iss_op}, {28'b0, op});
        chk({req, " R10 dst"}, {26'b0, iss_dst}, {26'b0, dst});
        chk({req, " R10 val_a"}, iss_val_a, va);
        chk({req, " R10 val_b"}, iss_val_b, vb);
    endtask

    // mode 0: ready bit set, mode 1: tag zero, mode 2: waiting on a tag
    task automatic sweep_one(input int ma, input int mb);
        int idx = ma * 3 + mb;
        logic [31:0] ea = (ma == 2) ? 32'h5000_0000 + idx : 32'hA000_0000 + idx;
        logic [31:0] eb = (mb == 2) ? 32'h9000_0000 + idx : 32'hB000_0000 + idx;
        tick();
        put(4'(idx), 6'(idx + 1),
            (ma == 1) ? 6'd0 : 6'd5, ma == 0, 32'hA000_0000 + idx,
            (mb == 1) ? 6'd0 : 6'd9, mb == 0, 32'hB000_0000 + idx);
        tick();
        disp_valid = 0; bc_valid = 1; bc_tag = 6'd33; bc_value = 32'hDEAD_0000;
        #1;
        if (ma != 2 && mb != 2) begin
            see_issue("R2 present on entry", 4'(idx), 6'(idx + 1), ea, eb);
        end else begin
            chk("R3 waits for tag", {31'b0, iss_valid}, 0);
            tick();
            bc_valid = 0; bc_tag = (ma == 2) ? 6'd5 : 6'd9;
            #1;
            chk("R4 nonmatching tag", {31'b0, iss_valid}, 0);
            tick();
            bc_valid = 1; bc_value = (ma == 2) ? ea : eb;
            #1;
            chk("R4 invalid broadcast", {31'b0, iss_valid}, 0);
            if (ma == 2 && mb == 2) begin
                tick();
                bc_tag = 6'd9; bc_value = eb;
                #1;
                chk("R3 one source still waiting", {31'b0, iss_valid}, 0);
            end
            tick();
            bc_valid = 0;
            #1;
            see_issue("R3 woken", 4'(idx), 6'(idx + 1), ea, eb);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        chk("R1 disp_ready", {31'b0, disp_ready}, 1);
        chk("R1 iss_valid", {31'b0, iss_valid}, 0);

        for (int ma = 0; ma < 3; ma++)
            for (int mb = 0; mb < 3; mb++)
                sweep_one(ma, mb);

        // R5: broadcast coinciding with insertion
        tick(); idle();
        put(4'd3, 6'd20, 6'd7, 0, 32'h0, 6'd0, 0, 32'h1111);
        bc_valid = 1; bc_tag = 6'd7; bc_value = 32'h7777;
        tick(); idle(); #1;
        see_issue("R5 same-cycle wake", 4'd3, 6'd20, 32'h7777, 32'h1111);

        // R6: busy unit holds a ready entry
        tick(); idle(); fu_busy = 1;
        put(4'd4, 6'd40, 6'd0, 1, 32'h40, 6'd0, 1, 32'h41);
        tick(); disp_valid = 0; #1;
        chk("R6 busy holds", {31'b0, iss_valid}, 0);
        for (int k = 0; k < 3; k++) begin
            tick(); #1;
            chk("R6 busy holds", {31'b0, iss_valid}, 0);
        end
        tick(); fu_busy = 0; #1;
        see_issue("R6 after busy", 4'd4, 6'd40, 32'h40, 32'h41);

        // R7, R8, R9: fill, overflow, drain in order
        for (int k = 1; k <= DEPTH; k++) begin
            tick(); idle(); fu_busy = 1;
            put(4'(k), 6'(k), 6'd0, 1, 32'(k * 16), 6'd0, 1, 32'(k * 16 + 1));
            #1;
            chk("R7 space before full", {31'b0, disp_ready}, 1);
        end
        tick();
        put(4'd9, 6'd50, 6'd0, 1, 32'h50, 6'd0, 1, 32'h51);
        #1;
        chk("R7 full refuses", {31'b0, disp_ready}, 0);
        tick(); disp_valid = 0; fu_busy = 0; #1;
        see_issue("R8 drain order", 4'd1, 6'd1, 32'd16, 32'd17);
        chk("R9 no refill in issue cycle", {31'b0, disp_ready}, 0);
        tick(); #1;
        chk("R9 slot freed", {31'b0, disp_ready}, 1);
        for (int k = 2; k <= DEPTH; k++) begin
            see_issue("R8 drain order", 4'(k), 6'(k), 32'(k * 16), 32'(k * 16 + 1));
            tick(); #1;
        end
        chk("R7 refused entry absent", {31'b0, iss_valid}, 0);

        // R8: oldest waiting entry sits above a younger one in slot order
        tick(); idle(); fu_busy = 1;
        put(4'd1, 6'd11, 6'd0, 1, 32'h11, 6'd0, 1, 32'h12);
        tick(); put(4'd2, 6'd12, 6'd20, 0, 32'h0, 6'd0, 1, 32'h22);
        tick(); put(4'd3, 6'd13, 6'd0, 1, 32'h31, 6'd0, 1, 32'h32);
        tick(); disp_valid = 0; fu_busy = 0; #1;
        see_issue("R8 oldest first", 4'd1, 6'd11, 32'h11, 32'h12);
        tick(); #1;
        see_issue("R8 skips waiting", 4'd3, 6'd13, 32'h31, 32'h32);
        tick(); fu_busy = 1;
        put(4'd4, 6'd14, 6'd0, 1, 32'h41, 6'd0, 1, 32'h42);
        tick(); disp_valid = 0; bc_valid = 1; bc_tag = 6'd20; bc_value = 32'h2020;
        #1;
        chk("R6 busy holds", {31'b0, iss_valid}, 0);
        tick(); bc_valid = 0; fu_busy = 0; #1;
        see_issue("R8 age over slot", 4'd2, 6'd12, 32'h2020, 32'h22);
        tick(); #1;
        see_issue("R8 younger next", 4'd4, 6'd14, 32'h41, 32'h42);
        tick(); #1;
        chk("R8 queue empty", {31'b0, iss_valid}, 0);

        // R11: one broadcast wakes many operands
        tick(); idle(); fu_busy = 1;
        put(4'd6, 6'd60, 6'd12, 0, 32'h0, 6'd12, 0, 32'h0);
        tick(); put(4'd7, 6'd61, 6'd0, 1, 32'h61, 6'd12, 0, 32'h0);
        tick(); disp_valid = 0; bc_valid = 1; bc_tag = 6'd12; bc_value = 32'h1212;
        tick(); bc_valid = 0; fu_busy = 0; #1;
        see_issue("R11 shared tag", 4'd6, 6'd60, 32'h1212, 32'h1212);
        tick(); #1;
        see_issue("R11 shared tag", 4'd7, 6'd61, 32'h61, 32'h1212);
        tick(); #1;
        chk("R11 queue empty", {31'b0, iss_valid}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule